// File: doc/BRIEF.md
# Wrapping Burst Read Address Generator

This block produces the byte address stream for a read burst on a serial-flash style port. A small volatile configuration register selects whether the burst stays inside an aligned window (8, 16, 32 or 64 bytes) or runs linearly through the whole 24-bit space. It also holds a latency field that sets how many dummy cycles come before the first data byte.

A read begins when `rd_start` is sampled high while `cs_n` is low. At that edge the block captures the 24-bit start address, the command class and the wrap settings. It then counts out the dummy cycles and raises `data_ready`. From then on `addr_out` shows the address of the current byte, and each sampled `beat` moves it to the next one. Raising `cs_n` ends the burst at the next clock edge. Command decoding, lane serialization and the storage array belong to the neighbouring logic.

Top module: `burst_addr_gen`

## Requirements
- R1: After reset the configuration readback `cfg_rdata` is 0x70 and `data_ready` is low.
- R2: A write with `cfg_we` high stores `cfg_wdata[6:0]` at the next edge. Bit 7 of `cfg_rdata` always reads 0. The field layout is: bits [6:5] window code, bit 4 wrap-off, bits [3:0] latency.
- R3: The wrap-off bit is active low. Value 0 makes bursts wrap and value 1 makes them linear.
- R4: Window code 00/01/10/11 selects 8/16/32/64 bytes. A wrapping burst starts at the start address and returns to the start of the aligned window that holds it. The address bits above the window never change.
- R5: With wrapping off, addresses increment by one per beat and roll over from 0xFFFFFF to 0x000000.
- R6: For classes 0 to 4 (0 fast, 1 dual-out, 2 quad-out, 3 dual-I/O, 4 quad-I/O), a latency field n in 1..15 gives exactly n dummy cycles. `data_ready` rises at the n-th edge after the edge that samples the start.
- R7: A latency field of 0 selects fixed counts: 8 for classes 0, 1 and 2, 4 for class 3 and 6 for class 4. Classes 5 to 7 are plain reads with no dummy cycles whatever the field holds, so `data_ready` rises at the start edge.
- R8: `beat` has no effect during the dummy phase. The first address shown with `data_ready` is the start address.
- R9: `cs_n` sampled high returns the block to idle at that edge, with `data_ready` low, whether it arrives during the dummy phase or the data phase.
- R10: `rd_start` is ignored during a burst and while `cs_n` is high.
- R11: The wrap settings and the dummy count are captured at the start edge. A configuration write during a burst does not change that burst.
- R12: `addr_out` moves to the next address at each edge where `beat` is sampled high in the data phase, and holds otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 7 | Configuration write data (window code, wrap-off, latency) |
| cfg_rdata | output | 8 | Configuration readback, bit 7 reads 0 |
| cs_n | input | 1 | Chip select, active low; high aborts the burst |
| rd_start | input | 1 | Start of a read burst |
| rd_addr | input | 24 | Start byte address |
| rd_class | input | 3 | Command class |
| beat | input | 1 | Byte-advance strobe |
| data_ready | output | 1 | High while data addresses are valid |
| addr_out | output | 24 | Address of the current data byte |

## Verification
`data_ready` is due at the n-th edge after the start edge, where n is the dummy count the class and latency field call for, and n = 0 means the start edge itself. The bench counts falling edges from the start edge until the flag appears and compares that count with n. Each `addr_out` value belongs to the data cycle in which it is shown. A monitor samples it just after each falling edge, when `beat` is high, and compares it with the front of a queue the driver filled from the window rules. The monitor's next pop therefore sees the value after one more edge. An abort must appear one edge after `cs_n` rises, and the bench checks this at the falling edge that follows.

// File: rtl/burst_pkg.sv
package burst_pkg;

    localparam int CFG_LAT_W = 4;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_DUMMY = 2'd1,
        ST_DATA  = 2'd2
    } seq_state_e;

    // Configuration register layout, MSB first below the reserved bit
    typedef struct packed {
        logic [1:0]           wrap_len;
        logic                 wrap_off;
        logic [CFG_LAT_W-1:0] lat;
    } cfg_t;

    localparam cfg_t CFG_RESET = '{wrap_len: 2'b11, wrap_off: 1'b1, lat: '0};

endpackage

// File: rtl/burst_cfg_reg.sv
module burst_cfg_reg
    import burst_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cfg_we_i,
    input  logic [6:0] cfg_wdata_i,
    output cfg_t       cfg_o,
    output logic [7:0] cfg_rdata_o
);

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (cfg_we_i) begin
            cfg_d = cfg_t'(cfg_wdata_i);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= CFG_RESET;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign cfg_o       = cfg_q;
    assign cfg_rdata_o = {1'b0, cfg_q};

    AST_CFG_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we_i |=> (cfg_rdata_o[6:0] == $past(cfg_wdata_i))); // R2

    AST_CFG_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_we_i |=> $stable(cfg_rdata_o)); // R2

endmodule

// File: rtl/burst_lat_sel.sv
module burst_lat_sel #(
    parameter int LAT_W         = 4,
    parameter int N_VAR_CLASSES = 5,
    parameter int DEF_FAST      = 8,
    parameter int DEF_DUAL_OUT  = 8,
    parameter int DEF_QUAD_OUT  = 8,
    parameter int DEF_DUAL_IO   = 4,
    parameter int DEF_QUAD_IO   = 6
) (
    input  logic [2:0]       cls_i,
    input  logic [LAT_W-1:0] lat_field_i,
    output logic [LAT_W-1:0] dummy_o
);

    logic [LAT_W-1:0] fixed_cnt;

    // Built-in count per class when the programmable field is zero
    always_comb begin
        unique case (cls_i)
            3'd0:    fixed_cnt = LAT_W'(DEF_FAST);
            3'd1:    fixed_cnt = LAT_W'(DEF_DUAL_OUT);
            3'd2:    fixed_cnt = LAT_W'(DEF_QUAD_OUT);
            3'd3:    fixed_cnt = LAT_W'(DEF_DUAL_IO);
            3'd4:    fixed_cnt = LAT_W'(DEF_QUAD_IO);
            default: fixed_cnt = '0;
        endcase
    end

    always_comb begin
        if (cls_i >= 3'(N_VAR_CLASSES)) begin
            dummy_o = '0;
        end else if (lat_field_i != '0) begin
            dummy_o = lat_field_i;
        end else begin
            dummy_o = fixed_cnt;
        end
    end

endmodule

// File: rtl/burst_seq.sv
module burst_seq
    import burst_pkg::*;
#(
    parameter int ADDR_W       = 24,
    parameter int LAT_W        = 4,
    parameter int MIN_WIN_LOG2 = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n_i,
    input  logic              start_i,
    input  logic [ADDR_W-1:0] start_addr_i,
    input  logic              wrap_off_i,
    input  logic [1:0]        wrap_len_i,
    input  logic [LAT_W-1:0]  dummy_i,
    input  logic              beat_i,
    output logic              ready_o,
    output logic [ADDR_W-1:0] addr_o
);

    localparam int HOLD_LSB = MIN_WIN_LOG2 + 3;

    typedef struct packed {
        seq_state_e        state;
        logic [ADDR_W-1:0] base;
        logic [ADDR_W-1:0] ofs;
        logic [LAT_W-1:0]  dcnt;
        logic              wrap_on;
        logic [1:0]        wlen;
    } seq_t;

    seq_t seq_d, seq_q;

    logic [ADDR_W-1:0] win_mask;
    logic [ADDR_W-1:0] lin_addr;

    always_comb begin
        win_mask = (ADDR_W'(1) << (MIN_WIN_LOG2 + int'(seq_q.wlen))) - ADDR_W'(1);
        lin_addr = seq_q.base + seq_q.ofs;
        if (seq_q.wrap_on) begin
            addr_o = (seq_q.base & ~win_mask) | (lin_addr & win_mask);
        end else begin
            addr_o = lin_addr;
        end
        ready_o = (seq_q.state == ST_DATA);
    end

    always_comb begin
        seq_d = seq_q;
        unique case (seq_q.state)
            ST_IDLE: begin
                if (!cs_n_i && start_i) begin
                    seq_d.base    = start_addr_i;
                    seq_d.ofs     = '0;
                    seq_d.wrap_on = !wrap_off_i;
                    seq_d.wlen    = wrap_len_i;
                    seq_d.dcnt    = dummy_i;
                    seq_d.state   = (dummy_i == '0) ? ST_DATA : ST_DUMMY;
                end
            end
            ST_DUMMY: begin
                seq_d.dcnt = seq_q.dcnt - LAT_W'(1);
                if (seq_q.dcnt == LAT_W'(1)) begin
                    seq_d.state = ST_DATA;
                end
            end
            ST_DATA: begin
                if (beat_i) begin
                    seq_d.ofs = seq_q.ofs + ADDR_W'(1);
                end
            end
            default: seq_d.state = ST_IDLE;
        endcase
        if (cs_n_i) begin
            seq_d.state = ST_IDLE;
            seq_d.dcnt  = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q <= '{state: ST_IDLE, base: '0, ofs: '0, dcnt: '0, wrap_on: 1'b0, wlen: 2'b11};
        end else begin
            seq_q <= seq_d;
        end
    end

    AST_ABORT_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n_i |=> !ready_o); // R9

    AST_FIRST_IS_START: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ready_o) |-> (addr_o == seq_q.base)); // R8

    AST_WINDOW_UPPER_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (ready_o && seq_q.wrap_on) |-> (addr_o[ADDR_W-1:HOLD_LSB] == seq_q.base[ADDR_W-1:HOLD_LSB])); // R4

    AST_BURST_KEEPS_GOING: assert property (@(posedge clk) disable iff (!rst_n)
        (ready_o && !cs_n_i) |=> ready_o); // R10

    AST_BEAT_STEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (ready_o && beat_i && !cs_n_i) |=> (addr_o != $past(addr_o))); // R12

    AST_IDLE_BEAT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (ready_o && !beat_i && !cs_n_i) |=> $stable(addr_o)); // R12

    AST_DUMMY_COUNT_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.state == ST_DUMMY) |-> (seq_q.dcnt != '0)); // R6

endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
    import burst_pkg::*;
#(
    parameter int ADDR_W       = 24,
    parameter int MIN_WIN_LOG2 = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [6:0]        cfg_wdata,
    output logic [7:0]        cfg_rdata,
    input  logic              cs_n,
    input  logic              rd_start,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic [2:0]        rd_class,
    input  logic              beat,
    output logic              data_ready,
    output logic [ADDR_W-1:0] addr_out
);

    cfg_t                 cfg;
    logic [CFG_LAT_W-1:0] dummy_cnt;

    burst_cfg_reg u_cfg (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg_we_i    (cfg_we),
        .cfg_wdata_i (cfg_wdata),
        .cfg_o       (cfg),
        .cfg_rdata_o (cfg_rdata)
    );

    burst_lat_sel #(
        .LAT_W (CFG_LAT_W)
    ) u_lat (
        .cls_i       (rd_class),
        .lat_field_i (cfg.lat),
        .dummy_o     (dummy_cnt)
    );

    burst_seq #(
        .ADDR_W       (ADDR_W),
        .LAT_W        (CFG_LAT_W),
        .MIN_WIN_LOG2 (MIN_WIN_LOG2)
    ) u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .cs_n_i       (cs_n),
        .start_i      (rd_start),
        .start_addr_i (rd_addr),
        .wrap_off_i   (cfg.wrap_off),
        .wrap_len_i   (cfg.wrap_len),
        .dummy_i      (dummy_cnt),
        .beat_i       (beat),
        .ready_o      (data_ready),
        .addr_o       (addr_out)
    );

    AST_IDLE_WHEN_DESELECTED: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n && !data_ready) |=> !data_ready); // R10

endmodule

// File: tb/burst_addr_gen_tb_top.sv
module burst_addr_gen_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [6:0]  cfg_wdata = '0;
    logic [7:0]  cfg_rdata;
    logic        cs_n = 1'b1;
    logic        rd_start = 1'b0;
    logic [23:0] rd_addr = '0;
    logic [2:0]  rd_class = '0;
    logic        beat = 1'b0;
    logic        data_ready;
    logic [23:0] addr_out;

    int n_checks = 0;
    int n_fail   = 0;
    logic [23:0] exp_q[$];
    string cur_req = "R4";

    always #5 clk = ~clk;

    burst_addr_gen dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_we     (cfg_we),
        .cfg_wdata  (cfg_wdata),
        .cfg_rdata  (cfg_rdata),
        .cs_n       (cs_n),
        .rd_start   (rd_start),
        .rd_addr    (rd_addr),
        .rd_class   (rd_class),
        .beat       (beat),
        .data_ready (data_ready),
        .addr_out   (addr_out)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    function automatic int exp_lat(input logic [6:0] c, input logic [2:0] cls);
        if (cls >= 3'd5) return 0;
        if (c[3:0] != 4'd0) return int'(c[3:0]);
        case (cls)
            3'd0, 3'd1, 3'd2: return 8;
            3'd3:             return 4;
            default:          return 6;
        endcase
    endfunction

    function automatic logic [23:0] exp_addr(input logic [6:0] c, input logic [23:0] a, input int i);
        logic [23:0] mask;
        logic [23:0] lin;
        mask = (24'd8 << c[6:5]) - 24'd1;
        lin  = a + 24'(i);
        if (!c[4]) return (a & ~mask) | (lin & mask);
        return lin;
    endfunction

    // Monitor: compare each presented data address with the scoreboard
    initial begin
        forever begin
            @(negedge clk);
            #1;
            if (data_ready && beat && !cs_n) begin
                if (exp_q.size() == 0) begin
                    check({cur_req, " unexpected beat"}, 32'(addr_out), 32'hDEAD);
                end else begin
                    check(cur_req, 32'(addr_out), 32'(exp_q.pop_front()));
                end
            end
        end
    end

    task automatic write_cfg(input logic [6:0] v);
        @(negedge clk);
        cfg_we = 1'b1;
        cfg_wdata = v;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic do_burst(input logic [6:0] c, input logic [23:0] a, input logic [2:0] cls,
                            input int nb, input bit beat_in_dummy, input bit gappy,
                            input bit mid_cfg, input bit mid_start, input string req);
        int lat_seen;
        int sent;
        cur_req = req;
        write_cfg(c);
        for (int i = 0; i < nb; i++) exp_q.push_back(exp_addr(c, a, i));
        @(negedge clk);
        cs_n = 1'b0;
        rd_start = 1'b1;
        rd_addr = a;
        rd_class = cls;
        @(negedge clk);
        rd_start = 1'b0;
        rd_addr = 24'h5A5A5A;
        beat = beat_in_dummy;
        if (mid_cfg) begin
            cfg_we = 1'b1;
            cfg_wdata = 7'h7F;
        end
        lat_seen = 0;
        while (!data_ready && lat_seen < 40) begin
            @(negedge clk);
            cfg_we = 1'b0;
            lat_seen++;
        end
        cfg_we = 1'b0;
        check({req, " R6/R7 dummy count"}, 32'(lat_seen), 32'(exp_lat(c, cls)));
        sent = 0;
        for (int k = 0; sent < nb; k++) begin
            beat = (!gappy) || (k % 2 == 0);
            rd_start = mid_start && (k == 2);
            if (beat) sent++;
            @(negedge clk);
        end
        beat = 1'b0;
        rd_start = 1'b0;
        cs_n = 1'b1;
        @(negedge clk);
        check("R9 ready low after deselect", 32'(data_ready), 32'd0);
        check({req, " R12 all beats consumed"}, 32'(exp_q.size()), 32'd0);
        exp_q.delete();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 cfg reset value", 32'(cfg_rdata), 32'h70);
        check("R1 ready low after reset", 32'(data_ready), 32'd0);

        write_cfg(7'h7F);
        check("R2 readback 7F", 32'(cfg_rdata), 32'h7F);
        write_cfg(7'h2A);
        check("R2 readback 2A, bit 7 zero", 32'(cfg_rdata), 32'h2A);

        // Default-like linear, fixed latency for fast class
        do_burst(7'h70, 24'h001234, 3'd0, 5, 0, 0, 0, 0, "R5 R7 linear fast");
        // 8-byte wrap, latency 3, quad-I/O
        do_burst(7'h03, 24'h000105, 3'd4, 6, 0, 0, 0, 0, "R3 R4 R6 wrap8");
        // 16-byte wrap, fixed latency for dual-I/O
        do_burst(7'h20, 24'h00ABCE, 3'd3, 20, 0, 0, 0, 0, "R4 R7 wrap16");
        // 32-byte wrap, latency 15, dual-out
        do_burst(7'h4F, 24'h123457, 3'd1, 40, 0, 0, 0, 0, "R4 R6 wrap32");
        // 64-byte wrap, fixed latency for quad-out, near the top of the space
        do_burst(7'h60, 24'hFFFFC3, 3'd2, 70, 0, 0, 0, 0, "R4 R7 wrap64");
        // Fixed latency for quad-I/O
        do_burst(7'h00, 24'h000040, 3'd4, 3, 0, 0, 0, 0, "R7 quad-io fixed");
        // Linear rollover, plain read class
        do_burst(7'h12, 24'hFFFFFE, 3'd5, 4, 0, 0, 0, 0, "R5 R7 rollover");
        // Class 7 ignores a nonzero latency field
        do_burst(7'h75, 24'h000010, 3'd7, 2, 0, 0, 0, 0, "R7 class7");
        // Beat held high through the dummy phase
        do_burst(7'h06, 24'h00033B, 3'd0, 10, 1, 0, 0, 0, "R8 beat in dummy");
        // Gaps between beats
        do_burst(7'h21, 24'h000777, 3'd1, 9, 0, 1, 0, 0, "R12 gapped beats");
        // Configuration write during the dummy phase
        do_burst(7'h05, 24'h00F00D, 3'd0, 12, 0, 0, 1, 0, "R11 cfg during burst");
        check("R2 R11 cfg updated after burst", 32'(cfg_rdata), 32'h7F);
        // Start pulse during the data phase
        do_burst(7'h00, 24'h000A09, 3'd2, 12, 0, 0, 0, 1, "R10 start ignored in burst");

        // Start while deselected: nothing happens
        @(negedge clk);
        cs_n = 1'b1;
        rd_class = 3'd5;
        rd_start = 1'b1;
        @(negedge clk);
        rd_start = 1'b0;
        repeat (3) @(negedge clk);
        check("R10 start with cs_n high ignored", 32'(data_ready), 32'd0);

        // Abort during the dummy phase
        write_cfg(7'h0F);
        @(negedge clk);
        cs_n = 1'b0;
        rd_class = 3'd0;
        rd_start = 1'b1;
        @(negedge clk);
        rd_start = 1'b0;
        repeat (3) @(negedge clk);
        cs_n = 1'b1;
        @(negedge clk);
        cs_n = 1'b0;
        repeat (20) @(negedge clk);
        check("R9 abort in dummy stays idle", 32'(data_ready), 32'd0);
        cs_n = 1'b1;

        // A fresh burst after the abort still works
        do_burst(7'h10, 24'h000100, 3'd5, 3, 0, 0, 0, 0, "R9 R5 after abort");

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: run did not finish actual=hung expected=done");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule